// File: doc/BRIEF.md
# Coincidence Delay-Line Time-to-Place Converter

This block measures the time between two spikes without a counter or a flash comparator. Each spike goes through a rising-edge pulse shaper that emits a pulse a fixed, configurable number of delay steps long. The two pulses enter two tapped delay lines from opposite ends and travel towards each other. The lines advance once per delay step, and a step lasts a configurable number of clock cycles. Each tap pair feeds a coincidence detector. A detector has its own weight and shares a threshold, a coincidence window and a refractory time with the others. The detector where the pulses meet fires, so the time difference becomes a place code.

A winner-take-all stage with memory takes the first firing detector, and the lowest index if several fire together. It reports that index as a one-cycle result and keeps the one-hot place code for a slow serial shift-out. If nothing fires within a bounded number of steps, a no-result pulse ends the conversion. Three spike-pair sources share the one converter core through a channel select. Configuration is only accepted while the converter is idle.

Top module: `tdcp_conv`

## Requirements
- R1: After reset the converter is idle, `res_valid`, `res_none` and `sh_dout` are 0. The defaults are one cycle per step, a pulse width of 1 step, a window of 0, a threshold of 2, a refractory time of 0 and a weight of 1 for every detector, so two spikes raised together give index (N_DET-1)/2.
- R2: Only the spike pair of the channel picked by `chan_sel` (0, 1 or 2) reaches the core. Edges on any other channel start no conversion and produce no result.
- R3: A rising edge of a spike input launches a pulse `cfg_pw` delay steps long into its line. With window 0 and threshold 2, an odd separation of one step gives no result at width 1 and gives index (N_DET-2+d)/2 at width 2.
- R4: Line A enters at tap 0 and line B at tap N_DET-1. For spike B arriving d steps after spike A (d even, negative when B comes first), width 1, window 0 and threshold 2, the result index is (N_DET-1+d)/2.
- R5: A detector keeps its weighted sum open for `cfg_win` further steps after its first input. With window 1, an odd separation d gives the index (N_DET-2+d)/2.
- R6: A detector fires when its accumulated sum of weight per present pulse reaches `cfg_thr`, using its own weight written through `wt_we`/`wt_sel`/`wt_val`. An unreachable threshold gives no result.
- R7: After firing, a detector ignores its inputs for `cfg_ref` clock cycles, then responds again.
- R8: A delay step lasts `cfg_tap` clock cycles (0 taken as 1). With a step of 2 cycles, a separation of 4 cycles maps to index (N_DET-1+2)/2.
- R9: The winner is the lowest-index detector among those firing first. `res_valid` is high for exactly one cycle with that index in `res_idx`, and the stored place code is one-hot at that index.
- R10: If no detector fires within 2*N_DET steps of the first step, `res_none` pulses for one cycle. With a one-cycle step it appears 2*N_DET+1 cycles after the first spike is raised, and the stored place code is all zero.
- R11: `cfg_we` and `wt_we` take effect only while idle. Writes during a conversion change neither that result nor later ones.
- R12: Each `sh_en` cycle shifts the stored place code out one bit, most significant detector first. `sh_dout` shows the current bit before the shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_sel | input | 2 | Source channel picked for the core |
| spk_a | input | 3 | First spike input of each channel |
| spk_b | input | 3 | Second spike input of each channel |
| cfg_we | input | 1 | Load the configuration fields (idle only) |
| cfg_tap | input | 4 | Clock cycles per delay step |
| cfg_pw | input | 4 | Shaped pulse width in steps |
| cfg_win | input | 4 | Coincidence window in steps |
| cfg_thr | input | 6 | Firing threshold |
| cfg_ref | input | 8 | Refractory time in cycles |
| wt_we | input | 1 | Write one detector weight (idle only) |
| wt_sel | input | 5 | Detector picked for the weight write |
| wt_val | input | 4 | Weight value |
| sh_en | input | 1 | Shift strobe for the serial readout |
| busy | output | 1 | Conversion in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_none | output | 1 | One-cycle no-result strobe |
| res_idx | output | 5 | Winning detector index |
| sh_dout | output | 1 | Serial place-code bit |

## Verification
The bench goes after the crossing cases. With an odd separation, two neighbouring detectors fire in the same step. A winner stage that does not pick the lowest index reports the upper one, and a window that is not held gives no result where an index is expected. It checks the timeout at its exact cycle: a step counter off by one moves `res_none` by a cycle. It also checks refractory blocking across back-to-back conversions, which a detector that ignores its rest time would answer with an index. Configuration and weight writes are placed mid-conversion; a design that took them would report a shifted or missing index on the following conversion.

// File: rtl/tdcp_pkg.sv
package tdcp_pkg;
  localparam int TAP_W = 4;
  localparam int PW_W  = 4;
  localparam int WIN_W = 4;
  localparam int WT_W  = 4;
  localparam int THR_W = 6;
  localparam int REF_W = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} conv_st_e;

  typedef struct packed {
    logic [TAP_W-1:0] tap;
    logic [PW_W-1:0]  pw;
    logic [WIN_W-1:0] win;
    logic [THR_W-1:0] thr;
    logic [REF_W-1:0] refr;
  } conv_cfg_t;
endpackage

// File: rtl/tdcp_shaper.sv
module tdcp_shaper #(
  parameter int PW_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spk,
  input  logic            step,
  input  logic            clr,
  input  logic [PW_W-1:0] pw,
  output logic            rise_o,
  output logic            pulse_o
);
  logic            spk_q;
  logic [PW_W-1:0] left;

  assign rise_o  = spk & ~spk_q;
  assign pulse_o = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spk_q <= 1'b0;
      left  <= '0;
    end else begin
      spk_q <= spk;
      if (rise_o)                  left <= (pw == '0) ? PW_W'(1) : pw;
      else if (clr)                left <= '0;
      else if (step && left != '0) left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/tdcp_cd.sv
module tdcp_cd #(
  parameter int WT_W  = 4,
  parameter int THR_W = 6,
  parameter int WIN_W = 4,
  parameter int REF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             in_a,
  input  logic             in_b,
  input  logic [WT_W-1:0]  wt,
  input  logic [THR_W-1:0] thr,
  input  logic [WIN_W-1:0] win_len,
  input  logic [REF_W-1:0] ref_len,
  output logic             fire
);
  localparam int ACC_W = THR_W + 1;

  logic [ACC_W-1:0] acc, s_now, base, tot;
  logic [ACC_W:0]   raw;
  logic [WIN_W-1:0] win_cnt;
  logic [REF_W-1:0] ref_cnt;
  logic             resting, hit;

  always_comb begin
    s_now   = (in_a ? ACC_W'(wt) : '0) + (in_b ? ACC_W'(wt) : '0);
    base    = (win_cnt != '0) ? acc : '0;
    raw     = {1'b0, base} + {1'b0, s_now};
    tot     = raw[ACC_W] ? '1 : raw[ACC_W-1:0];
    resting = (ref_cnt != '0);
    hit     = step && !clr && !resting && (s_now != '0) && (tot >= ACC_W'(thr));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      win_cnt <= '0;
      ref_cnt <= '0;
      fire    <= 1'b0;
    end else begin
      fire <= hit;
      if (hit)          ref_cnt <= ref_len;
      else if (resting) ref_cnt <= ref_cnt - 1'b1;
      if (clr || hit) begin
        acc     <= '0;
        win_cnt <= '0;
      end else if (step && !resting) begin
        if (win_cnt != '0) begin
          acc     <= tot;
          win_cnt <= win_cnt - 1'b1;
        end else if (s_now != '0) begin
          acc     <= s_now;
          win_cnt <= win_len;
        end
      end
    end
  end
endmodule

// File: rtl/tdcp_shout.sv
module tdcp_shout #(
  parameter int N = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         shift,
  output logic [N-1:0] code_o,
  output logic         dout
);
  logic [N-1:0] sreg;

  assign code_o = sreg;
  assign dout   = sreg[N-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= load_val;
    else if (shift) sreg <= {sreg[N-2:0], 1'b0};
  end
endmodule

// File: rtl/tdcp_conv.sv
module tdcp_conv
  import tdcp_pkg::*;
#(
  parameter int N_DET = 17,
  parameter int N_CH  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(N_CH)-1:0]    chan_sel,
  input  logic [N_CH-1:0]            spk_a,
  input  logic [N_CH-1:0]            spk_b,
  input  logic                       cfg_we,
  input  logic [TAP_W-1:0]           cfg_tap,
  input  logic [PW_W-1:0]            cfg_pw,
  input  logic [WIN_W-1:0]           cfg_win,
  input  logic [THR_W-1:0]           cfg_thr,
  input  logic [REF_W-1:0]           cfg_ref,
  input  logic                       wt_we,
  input  logic [$clog2(N_DET)-1:0]   wt_sel,
  input  logic [WT_W-1:0]            wt_val,
  input  logic                       sh_en,
  output logic                       busy,
  output logic                       res_valid,
  output logic                       res_none,
  output logic [$clog2(N_DET)-1:0]   res_idx,
  output logic                       sh_dout
);
  localparam int IDX_W     = $clog2(N_DET);
  localparam int CH_W      = $clog2(N_CH);
  localparam int TMO_STEPS = 2 * N_DET;
  localparam int CNT_W     = $clog2(TMO_STEPS + 1);
  localparam logic [IDX_W:0] N_DET_L = (IDX_W + 1)'(N_DET);

  // lowest set bit of a fire vector
  function automatic logic [N_DET-1:0] lowest_hot(input logic [N_DET-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [IDX_W-1:0] hot_to_idx(input logic [N_DET-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_DET; i++) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  conv_st_e          state;
  conv_cfg_t         cfg_q;
  logic [WT_W-1:0]   wt_r [N_DET];
  logic [TAP_W-1:0]  div;
  logic [CNT_W-1:0]  stp_cnt;
  logic [N_DET-1:0]  line_a, line_b, fire_vec, win_vec, place_code;
  logic              sel_a, sel_b, rise_a, rise_b, inj_a, inj_b;
  logic              idle, start, step, hit, tmo, det_step;

  // channel multiplexer
  always_comb begin
    sel_a = 1'b0;
    sel_b = 1'b0;
    for (int c = 0; c < N_CH; c++) begin
      if (chan_sel == CH_W'(c)) begin
        sel_a = spk_a[c];
        sel_b = spk_b[c];
      end
    end
  end

  assign idle     = (state == ST_IDLE);
  assign busy     = (state == ST_RUN);
  assign start    = idle && (rise_a || rise_b);
  assign step     = busy && (div == '0);
  assign hit      = busy && (fire_vec != '0);
  assign tmo      = step && !hit && (stp_cnt == CNT_W'(TMO_STEPS - 1));
  assign det_step = step && !hit;
  assign win_vec  = lowest_hot(fire_vec);

  tdcp_shaper #(.PW_W(PW_W)) u_shp_a (
    .clk(clk), .rst_n(rst_n), .spk(sel_a), .step(step), .clr(idle),
    .pw(cfg_q.pw), .rise_o(rise_a), .pulse_o(inj_a));

  tdcp_shaper #(.PW_W(PW_W)) u_shp_b (
    .clk(clk), .rst_n(rst_n), .spk(sel_b), .step(step), .clr(idle),
    .pw(cfg_q.pw), .rise_o(rise_b), .pulse_o(inj_b));

  // sequencing: step divider and timeout counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      div     <= '0;
      stp_cnt <= '0;
    end else if (idle) begin
      div     <= '0;
      stp_cnt <= '0;
      if (start) state <= ST_RUN;
    end else begin
      if (hit || tmo) state <= ST_IDLE;
      div <= (({1'b0, div} + 1'b1) >= {1'b0, cfg_q.tap}) ? '0 : div + 1'b1;
      if (step) stp_cnt <= stp_cnt + 1'b1;
    end
  end

  // counter-running delay lines
  always_ff @(posedge clk) begin
    if (!rst_n || idle) begin
      line_a <= '0;
      line_b <= '0;
    end else if (step) begin
      line_a <= {line_a[N_DET-2:0], inj_a};
      line_b <= {inj_b, line_b[N_DET-1:1]};
    end
  end

  // configuration, accepted only while idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.tap  <= TAP_W'(1);
      cfg_q.pw   <= PW_W'(1);
      cfg_q.win  <= '0;
      cfg_q.thr  <= THR_W'(2);
      cfg_q.refr <= '0;
    end else if (cfg_we && idle) begin
      cfg_q.tap  <= cfg_tap;
      cfg_q.pw   <= cfg_pw;
      cfg_q.win  <= cfg_win;
      cfg_q.thr  <= cfg_thr;
      cfg_q.refr <= cfg_ref;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_DET; i++) wt_r[i] <= WT_W'(1);
    end else if (wt_we && idle && ({1'b0, wt_sel} < N_DET_L)) begin
      wt_r[wt_sel] <= wt_val;
    end
  end

  for (genvar g = 0; g < N_DET; g++) begin : g_det
    tdcp_cd #(.WT_W(WT_W), .THR_W(THR_W), .WIN_W(WIN_W), .REF_W(REF_W)) u_cd (
      .clk(clk), .rst_n(rst_n), .clr(idle), .step(det_step),
      .in_a(line_a[g]), .in_b(line_b[g]), .wt(wt_r[g]), .thr(cfg_q.thr),
      .win_len(cfg_q.win), .ref_len(cfg_q.refr), .fire(fire_vec[g]));
  end

  // winner-take-all with memory
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_none  <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= hit;
      res_none  <= tmo;
      if (hit) res_idx <= hot_to_idx(win_vec);
    end
  end

  tdcp_shout #(.N(N_DET)) u_shout (
    .clk(clk), .rst_n(rst_n), .load(hit || tmo),
    .load_val(hit ? win_vec : '0), .shift(sh_en),
    .code_o(place_code), .dout(sh_dout));
endmodule

// File: rtl/tdcp_conv_chk.sv
module tdcp_conv_chk
  import tdcp_pkg::*;
#(
  parameter int N_DET = 17,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             step,
  input logic             res_valid,
  input logic             res_none,
  input logic [IDX_W-1:0] res_idx,
  input logic [N_DET-1:0] place,
  input conv_cfg_t        cfg_word
);
  localparam int TMO_STEPS = 2 * N_DET;
  localparam int CNT_W     = $clog2(TMO_STEPS + 2);

  logic [CNT_W-1:0] run_steps;

  always_ff @(posedge clk) begin
    if (!rst_n)     run_steps <= '0;
    else if (!busy) run_steps <= '0;
    else if (step)  run_steps <= run_steps + 1'b1;
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_place_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot(place));
  assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_idx) < N_DET));
  assert_valid_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));
  assert_none_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_none |=> !res_none);
  assert_none_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_none));
  assert_none_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_none |-> (int'(run_steps) == TMO_STEPS));
  assert_none_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_none |-> (place == '0));
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_word));
endmodule

bind tdcp_conv tdcp_conv_chk #(.N_DET(N_DET), .IDX_W($clog2(N_DET))) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .step(step),
  .res_valid(res_valid), .res_none(res_none), .res_idx(res_idx),
  .place(place_code), .cfg_word(cfg_q));

// File: tb/tdcp_conv_bench.sv
module tdcp_conv_bench;
  localparam int N = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chan_sel = '0;
  logic [2:0] spk_a = '0, spk_b = '0;
  logic       cfg_we = 1'b0, wt_we = 1'b0, sh_en = 1'b0;
  logic [3:0] cfg_tap = 4'd1, cfg_pw = 4'd1, cfg_win = '0, wt_val = 4'd1;
  logic [5:0] cfg_thr = 6'd2;
  logic [7:0] cfg_ref = '0;
  logic [4:0] wt_sel = '0, res_idx;
  logic       busy, res_valid, res_none, sh_dout;

  int n_chk = 0, n_fail = 0;
  bit done = 0, pulse_low = 0;

  tdcp_conv u_tdcp_conv (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .spk_a(spk_a), .spk_b(spk_b),
    .cfg_we(cfg_we), .cfg_tap(cfg_tap), .cfg_pw(cfg_pw), .cfg_win(cfg_win),
    .cfg_thr(cfg_thr), .cfg_ref(cfg_ref), .wt_we(wt_we), .wt_sel(wt_sel),
    .wt_val(wt_val), .sh_en(sh_en), .busy(busy), .res_valid(res_valid),
    .res_none(res_none), .res_idx(res_idx), .sh_dout(sh_dout));

  always #4 clk = ~clk;

  function automatic int even_place(input int d); return (N - 1 + d) / 2; endfunction
  function automatic int odd_place(input int d);  return (N - 2 + d) / 2; endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic setcfg(input int tap, input int pw, input int win, input int thr, input int rf);
    @(negedge clk);
    cfg_tap = 4'(tap); cfg_pw = 4'(pw); cfg_win = 4'(win); cfg_thr = 6'(thr); cfg_ref = 8'(rf);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setwt(input int sel, input int val);
    @(negedge clk);
    wt_sel = 5'(sel); wt_val = 4'(val); wt_we = 1'b1;
    @(negedge clk);
    wt_we = 1'b0;
  endtask

  // kind: 1 result, 2 no-result, 0 nothing; d in cycles, B later when positive
  task automatic conv(input int ch, input int d, input bit poke,
                      output int kind, output int idx, output int cyc);
    int ad;
    ad = (d < 0) ? -d : d;
    kind = 0; idx = -1; cyc = 0;
    @(negedge clk);
    if (d >= 0) spk_a[ch] = 1'b1;
    if (d <= 0) spk_b[ch] = 1'b1;
    while (kind == 0 && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (res_valid) begin kind = 1; idx = int'(res_idx); end
      else if (res_none) kind = 2;
      if (cyc == ad) begin spk_a[ch] = 1'b1; spk_b[ch] = 1'b1; end
      if (poke && cyc == 2) begin
        cfg_tap = 4'd2; cfg_we = 1'b1; wt_sel = 5'd10; wt_val = 4'd0; wt_we = 1'b1;
      end
      if (poke && cyc == 3) begin cfg_we = 1'b0; wt_we = 1'b0; end
    end
    @(negedge clk);
    pulse_low = !res_valid && !res_none;
    spk_a = '0; spk_b = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic readout(output logic [N-1:0] code);
    for (int i = N - 1; i >= 0; i--) begin
      code[i] = sh_dout;
      sh_en = 1'b1;
      @(negedge clk);
      sh_en = 1'b0;
    end
  endtask

  task automatic expect_idx(input int ch, input int d, input int exp, input string rq);
    int k, ix, cy;
    conv(ch, d, 1'b0, k, ix, cy);
    chk(k == 1 && ix == exp, rq, ix, exp);
  endtask

  task automatic expect_none(input int d, input string rq);
    int k, ix, cy;
    conv(0, d, 1'b0, k, ix, cy);
    chk(k == 2, rq, k, 2);
  endtask

  task automatic t_reset;
    chk(!busy && !res_valid && !res_none && !sh_dout, "R1 reset outputs",
        int'({busy, res_valid, res_none, sh_dout}), 0);
    expect_idx(0, 0, even_place(0), "R1 default config");
  endtask

  task automatic t_chan;
    bit seen;
    seen = 0;
    chan_sel = 2'd0;
    @(negedge clk);
    spk_a[1] = 1'b1; spk_b[1] = 1'b1;
    repeat (60) begin
      @(negedge clk);
      if (busy || res_valid || res_none) seen = 1;
    end
    spk_a = '0; spk_b = '0;
    repeat (3) @(negedge clk);
    chk(!seen, "R2 unselected channel ignored", int'(seen), 0);
    chan_sel = 2'd1;
    expect_idx(1, 0, even_place(0), "R2 channel 1");
    chan_sel = 2'd2;
    expect_idx(2, 2, even_place(2), "R2 channel 2");
    chan_sel = 2'd0;
  endtask

  task automatic t_place;
    int k, ix, cy;
    logic [N-1:0] code;
    setcfg(1, 1, 0, 2, 0);
    conv(0, 4, 1'b0, k, ix, cy);
    chk(k == 1 && ix == even_place(4), "R4 B later by 4", ix, even_place(4));
    chk(pulse_low, "R9 valid one cycle", int'(pulse_low), 1);
    readout(code);
    chk(code == (N'(1) << even_place(4)), "R12 serial code MSB first", int'(code),
        int'(N'(1) << even_place(4)));
    expect_idx(0, -6, even_place(-6), "R4 A later by 6");
  endtask

  task automatic t_pw;
    int k, ix, cy;
    logic [N-1:0] code;
    setcfg(1, 1, 0, 2, 0);
    expect_none(1, "R3 width 1 odd gap");
    setcfg(1, 2, 0, 2, 0);
    conv(0, 1, 1'b0, k, ix, cy);
    chk(k == 1 && ix == odd_place(1), "R3 R9 width 2 tie lowest", ix, odd_place(1));
    readout(code);
    chk(code == (N'(1) << odd_place(1)), "R9 one-hot place code", int'(code),
        int'(N'(1) << odd_place(1)));
  endtask

  task automatic t_win;
    setcfg(1, 1, 1, 2, 0);
    expect_idx(0, 1, odd_place(1), "R5 window 1 B later");
    expect_idx(0, -1, odd_place(-1), "R5 window 1 A later");
  endtask

  task automatic t_tmo;
    int k, ix, cy;
    logic [N-1:0] code;
    setcfg(1, 1, 0, 2, 0);
    conv(0, 1, 1'b0, k, ix, cy);
    chk(k == 2 && cy == 2 * N + 1, "R10 timeout cycle", cy, 2 * N + 1);
    chk(pulse_low, "R10 none one cycle", int'(pulse_low), 1);
    readout(code);
    chk(code == '0, "R10 empty place code", int'(code), 0);
  endtask

  task automatic t_wt;
    setcfg(1, 1, 15, 3, 0);
    setwt(12, 2);
    expect_idx(0, 0, 12, "R6 heavy detector wins");
    setcfg(1, 1, 0, 5, 0);
    expect_none(0, "R6 threshold unreachable");
    setwt(12, 1);
  endtask

  task automatic t_ref;
    setcfg(1, 1, 0, 2, 150);
    expect_idx(0, 0, even_place(0), "R7 first fire");
    expect_none(0, "R7 resting detector silent");
    repeat (160) @(negedge clk);
    expect_idx(0, 0, even_place(0), "R7 fires after rest");
    setcfg(1, 1, 0, 2, 0);
  endtask

  task automatic t_tap;
    setcfg(2, 1, 0, 2, 0);
    expect_idx(0, 4, even_place(2), "R8 two-cycle step");
    setcfg(1, 1, 0, 2, 0);
    expect_idx(0, 4, even_place(4), "R8 one-cycle step");
  endtask

  task automatic t_busy_cfg;
    int k, ix, cy;
    setcfg(1, 1, 0, 2, 0);
    conv(0, 4, 1'b1, k, ix, cy);
    chk(k == 1 && ix == even_place(4), "R11 write during run", ix, even_place(4));
    expect_idx(0, 4, even_place(4), "R11 write was dropped");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chan();
    t_place();
    t_pw();
    t_win();
    t_tmo();
    t_wt();
    t_ref();
    t_tap();
    t_busy_cfg();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule